// File: doc/BRIEF.md
# Dual-Source Clock Supervisor with Automatic Failover

This block watches two clock sources, an internal oscillator clock and an external crystal clock, and passes one of them to its clock output. A counter running on a steady reference clock measures how long the selected source has gone without a rising edge. When monitoring is on and that silence lasts `TIMEOUT` reference cycles, the block moves the output to the other source without software action, but only if the other source is still toggling. It also sets a sticky failure flag. If software has enabled the interrupt, the interrupt line then stays high until software clears the flag.

Software reaches the block through a small register port on the reference clock. The control register holds four bits: monitor enable, interrupt enable, source select and failure flag. Because the select bit changes on a failover, the interrupt handler can read it to learn which source died. The flag clears only through a two-step sequence: a read made while the flag is set arms the clear, and the next write that carries 0 in the flag position completes it. Writing the other bits back after such a read therefore clears the flag as a side effect.

The output multiplexer is glitch-free. It closes the gate of the old clock on that clock's own falling edge, and only then opens the gate of the new clock on the new clock's falling edge. A branch whose clock has stopped is forced off asynchronously, so a hand-over away from a dead source still completes.

Top module: `clk_mon_failover`

## Requirements
- R1: After reset, the control register reads 0. This means monitoring is off, the interrupt is disabled, the internal clock is selected (select = 0) and the flag is 0. `irq` is 0 and `clk_out` follows `clk_int`.
- R2: The control register holds monitor enable in bit 0, interrupt enable in bit 1, source select in bit 2 (0 = internal, 1 = external) and the failure flag in bit 3. Bits above 3 read as 0. A write stores bits 0 to 2 as written. Writing 1 to bit 3 never sets the flag.
- R3: With monitoring on, suppose the selected source shows no rising edge for `TIMEOUT` reference cycles (measured after a two-stage synchronizer) while the other source is active. The select bit then flips to the other source and the flag sets.
- R4: Only the selected source is checked. A stopped unselected source never sets the flag or changes the select bit.
- R5: With monitoring off, a stopped selected source neither sets the flag nor changes the select bit.
- R6: If both sources are inactive while monitoring is on, the flag sets and the select bit keeps its value.
- R7: A write with bit 3 = 0 clears the flag only if it follows a read made while the flag was set. A write without such a prior read leaves the flag set.
- R8: Any write, including one with bit 3 = 1, uses up the armed state. A write with bit 3 = 1 after an arming read leaves the flag set.
- R9: `irq` is high exactly when the flag and the interrupt enable are both set. It stays high as a level until either one is cleared.
- R10: `clk_out` carries the selected source's period once a switch has settled. No output pulse is shorter than the shorter half-period of the two sources, and the two branch gates are never open at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock for the monitor counters and the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_int | input | 1 | Internal oscillator clock (source 0) |
| clk_ext | input | 1 | External crystal clock (source 1) |
| rd_en | input | 1 | Control register read strobe |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | REG_W | Control register write data |
| rd_data | output | REG_W | Control register read data |
| clk_out | output | 1 | Gated, selected output clock |
| irq | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
Each kind of internal fault shows up at a different port, and on a predictable schedule. A wrong monitor counter or synchronizer depth shows up as a missing or premature select flip, visible in `rd_data` about `TIMEOUT` plus three reference cycles after a source stops. A broken arm or clear state shows up on `irq` on the first write after a read. A faulty gate hand-over shows up as a short pulse or a stalled `clk_out` within a few periods of the slower source. The bench stops sources in every combination of select bit and enable bit, checks register contents and the interrupt after each step, and measures the output clock's period and minimum pulse width throughout.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
   // Control register bit positions, decoded by software.
   localparam int BIT_MON   = 0;
   localparam int BIT_IRQEN = 1;
   localparam int BIT_SEL   = 2;
   localparam int BIT_FLAG  = 3;
   localparam int CTRL_BITS = 4;
   localparam int NUM_SRC   = 2;
endpackage

// File: rtl/clkmon_activity.sv
module clkmon_activity #(
   parameter int TIMEOUT     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic src_clk,
   output logic active_o
);
   localparam int CW = $clog2(TIMEOUT + 1);

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("clkmon_activity: TIMEOUT must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkmon_activity: SYNC_STAGES must be at least 2");
   end

   // toggle once per rising edge of the watched source
   logic tgl_q;
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) tgl_q <= 1'b0;
      else        tgl_q <= ~tgl_q;
   end

   // synchronizer plus one history stage for change detection
   logic [SYNC_STAGES:0] sync_q;
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], tgl_q};
   end

   logic edge_seen;
   assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

   logic [CW-1:0] idle_q;
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)                    idle_q <= '0;
      else if (edge_seen)            idle_q <= '0;
      else if (idle_q != CW'(TIMEOUT)) idle_q <= idle_q + 1'b1;
   end

   assign active_o = (idle_q != CW'(TIMEOUT));

   assert_edge_revives_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      edge_seen |=> active_o);
   assert_dead_stays_dead_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (!active_o && !edge_seen) |=> !active_o);
endmodule

// File: rtl/clkmon_regs.sv
module clkmon_regs
   import clkmon_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic [1:0]       act_i,
   output logic             sel_o,
   output logic [1:0]       kill_o,
   output logic             irq_o
);
   if (REG_W < CTRL_BITS) begin : g_bad_width
      $error("clkmon_regs: REG_W must hold all control bits");
   end

   logic mon_q, ien_q, sel_q, flag_q, arm_q;
   logic fail_evt, other_ok, clr_req;

   assign fail_evt = mon_q & ~act_i[sel_q];
   assign other_ok = act_i[~sel_q];
   assign clr_req  = wr_en & arm_q & ~wr_data[BIT_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_q  <= 1'b0;
         ien_q  <= 1'b0;
         sel_q  <= 1'b0;
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (wr_en) begin
            mon_q <= wr_data[BIT_MON];
            ien_q <= wr_data[BIT_IRQEN];
            sel_q <= wr_data[BIT_SEL];
         end
         // hardware failover takes priority over a software select write
         if (fail_evt && other_ok) sel_q <= ~sel_q;
         // a new failure wins over a clear in the same cycle
         if (fail_evt)     flag_q <= 1'b1;
         else if (clr_req) flag_q <= 1'b0;
         // any write consumes the armed state; a read arms only while flagged
         if (wr_en)                arm_q <= 1'b0;
         else if (rd_en && flag_q) arm_q <= 1'b1;
      end
   end

   // force-off request for a dead branch that is no longer selected
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_kill
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) kill_o[i] <= 1'b0;
         else        kill_o[i] <= (sel_q != 1'(i)) & ~act_i[i];
      end
   end

   always_comb begin
      rd_data            = '0;
      rd_data[BIT_MON]   = mon_q;
      rd_data[BIT_IRQEN] = ien_q;
      rd_data[BIT_SEL]   = sel_q;
      rd_data[BIT_FLAG]  = flag_q;
   end

   assign sel_o = sel_q;
   assign irq_o = flag_q & ien_q;

   assert_flag_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !arm_q) |=> flag_q);
   assert_no_flag_when_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i[sel_q] || !mon_q) |=> !$rose(flag_q));
   assert_no_flag_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_q |=> !$rose(flag_q));
   assert_failover_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_q && !act_i[sel_q] && act_i[~sel_q]) |=> (flag_q && (sel_q != $past(sel_q))));
   assert_both_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_q && !act_i[0] && !act_i[1] && !wr_en) |=> (flag_q && $stable(sel_q)));
endmodule

// File: rtl/clkmon_glitchfree_mux.sv
module clkmon_glitchfree_mux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       rst_n,
   input  logic [1:0] clk_i,
   input  logic       sel_i,
   input  logic [1:0] kill_i,
   output logic       clk_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkmon_glitchfree_mux: SYNC_STAGES must be at least 2");
   end

   logic [1:0] en;

   for (genvar i = 0; i < 2; i++) begin : g_br
      logic arst_n, want;
      logic [SYNC_STAGES-1:0] sh_q;
      assign arst_n = rst_n & ~kill_i[i];
      assign want   = (sel_i == 1'(i)) & ~en[1-i];
      // gate opens and closes only while this branch's clock is low
      always_ff @(negedge clk_i[i] or negedge arst_n) begin
         if (!arst_n) sh_q <= '0;
         else         sh_q <= {sh_q[SYNC_STAGES-2:0], want};
      end
      assign en[i] = sh_q[SYNC_STAGES-1];
   end

   assign clk_o = |(clk_i & en);

   always_comb begin
      if (rst_n) begin
         assert_gates_exclusive_R10: assert ($onehot0(en));
      end
   end
endmodule

// File: rtl/clk_mon_failover.sv
module clk_mon_failover
   import clkmon_pkg::*;
#(
   parameter int TIMEOUT     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int REG_W       = 8
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             clk_int,
   input  logic             clk_ext,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             clk_out,
   output logic             irq
);
   logic [NUM_SRC-1:0] src_clks, act, kill;
   logic               sel;

   assign src_clks = {clk_ext, clk_int};

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_mon
      clkmon_activity #(
         .TIMEOUT     (TIMEOUT),
         .SYNC_STAGES (SYNC_STAGES)
      ) mon_i (
         .ref_clk  (ref_clk),
         .rst_n    (rst_n),
         .src_clk  (src_clks[i]),
         .active_o (act[i])
      );
   end

   clkmon_regs #(.REG_W(REG_W)) regs_i (
      .clk     (ref_clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .act_i   (act),
      .sel_o   (sel),
      .kill_o  (kill),
      .irq_o   (irq)
   );

   clkmon_glitchfree_mux #(.SYNC_STAGES(SYNC_STAGES)) mux_i (
      .rst_n  (rst_n),
      .clk_i  (src_clks),
      .sel_i  (sel),
      .kill_i (kill),
      .clk_o  (clk_out)
   );
endmodule

// File: tb/clk_mon_failover_tb_top.sv
`timescale 1ns/1ps
module clk_mon_failover_tb_top;
   localparam int REG_W = 8;

   logic ref_clk = 1'b0, rst_n = 1'b0;
   logic clk_int = 1'b0, clk_ext = 1'b0;
   logic int_run = 1'b1, ext_run = 1'b1;
   logic rd_en = 1'b0, wr_en = 1'b0;
   logic [REG_W-1:0] wr_data = '0, rd_data;
   logic clk_out, irq;

   int checks = 0, errors = 0, glitches = 0;
   bit glitch_en = 1'b0, done = 1'b0;
   realtime last_t = 0.0;

   // bench model of the control register
   bit m_mon, m_ien, m_sel, m_flag, m_arm;

   clk_mon_failover #(.TIMEOUT(16), .SYNC_STAGES(2), .REG_W(REG_W)) dut_i (
      .ref_clk(ref_clk), .rst_n(rst_n), .clk_int(clk_int), .clk_ext(clk_ext),
      .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .clk_out(clk_out), .irq(irq));

   always #4 ref_clk = ~ref_clk;
   initial forever #10 clk_int = int_run ? ~clk_int : 1'b0;
   initial begin #3; forever #14 clk_ext = ext_run ? ~clk_ext : 1'b0; end

   always @(clk_out) begin
      if (glitch_en && ($realtime - last_t) < 9.0) glitches++;
      last_t = $realtime;
   end

   function automatic int exp_rd();
      return {m_flag, m_sel, m_ien, m_mon};
   endfunction

   task automatic chk(input string req, input string what, input int act, input int expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic wr(input logic [REG_W-1:0] d);
      @(negedge ref_clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge ref_clk);
      wr_en = 1'b0;
      m_mon = d[0]; m_ien = d[1]; m_sel = d[2];
      if (m_arm && !d[3]) m_flag = 1'b0;
      m_arm = 1'b0;
   endtask

   task automatic rd_chk(input string req);
      @(negedge ref_clk);
      rd_en = 1'b1;
      chk(req, "rd_data", int'(rd_data), exp_rd());
      @(negedge ref_clk);
      rd_en = 1'b0;
      if (m_flag) m_arm = 1'b1;
   endtask

   task automatic irq_chk(input string req);
      @(negedge ref_clk);
      chk(req, "irq", int'(irq), int'(m_flag & m_ien));
   endtask

   task automatic meas(input string req, input int expv);
      realtime t1, t2;
      @(posedge clk_out); @(posedge clk_out);
      t1 = $realtime;
      @(posedge clk_out);
      t2 = $realtime;
      chk(req, "clk_out period", int'(t2 - t1), expv);
   endtask

   initial begin
      repeat (100000) @(posedge ref_clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1C));
      idle(3);
      rst_n = 1'b1;
      idle(10);
      glitch_en = 1'b1;
      // R1: reset state
      rd_chk("R1");
      irq_chk("R1");
      meas("R1", 20);

      // R2: random register traffic with both sources alive
      for (int k = 0; k < 150; k++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[0]) wr({r[15:12], r[3], m_sel, r[2:1]});
         else      rd_chk("R2");
      end
      wr(8'h08);
      rd_chk("R2");
      irq_chk("R2");

      // R5: monitoring off, selected source stops
      int_run = 1'b0; idle(50);
      rd_chk("R5");
      int_run = 1'b1; idle(30);

      // R4: unselected source stops
      wr(8'h01);
      ext_run = 1'b0; idle(50);
      rd_chk("R4");
      meas("R4", 20);
      ext_run = 1'b1; idle(30);

      // R10: software switch in both directions
      wr(8'h04); idle(40);
      rd_chk("R2");
      meas("R10", 28);
      wr(8'h00); idle(40);
      meas("R10", 20);

      // R3: selected internal source fails, external takes over
      wr(8'h03);
      int_run = 1'b0; idle(50);
      m_sel = 1'b1; m_flag = 1'b1;
      rd_chk("R3");
      irq_chk("R9");
      meas("R10", 28);
      int_run = 1'b1; idle(20);

      // R8: write with bit 3 = 1 after arming read keeps flag and disarms
      wr(8'h0F);
      irq_chk("R8");
      // R7: write of 0 without a prior read does not clear
      wr(8'h07);
      irq_chk("R7");
      rd_chk("R7");
      wr(8'h07);
      rd_chk("R7");
      irq_chk("R9");

      // R6: both sources stop with external selected
      int_run = 1'b0; ext_run = 1'b0; idle(50);
      m_flag = 1'b1;
      rd_chk("R6");
      wr(8'h0D);
      irq_chk("R9");
      rd_chk("R9");
      int_run = 1'b1; ext_run = 1'b1; idle(40);
      wr(8'h05);
      rd_chk("R7");
      meas("R10", 28);

      chk("R10", "short output pulses", glitches, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule